// File: doc/BRIEF.md
# Page-Mode External Memory Bus Sequencer

This block runs a multiplexed external memory bus for a small processor core. Requests arrive on a valid/ready port carrying a 16-bit address, a flag that marks a code fetch or a data access, a read/write flag and write data. The block keeps the high address byte of the last page it put out. A request whose high byte matches that page runs only a short low-byte cycle. A request that misses first inserts a phase in which the high byte is presented on its own port and a latch strobe is pulsed, so that external latches can capture it.

The clock runs at twice the bus rate, so one tick is half a bus clock. A 2-bit mode input selects one-, two- or four-clock page timing. The miss phase lasts M ticks and the hit cycle lasts 2M ticks, where M is 1, 2 and 4 for modes 00, 01 and 10/11. The mode is sampled when a request is accepted and is held for the whole bus cycle. A read or fetch returns a byte on a response valid/ready port. Back-pressure on that port stalls new requests until the byte has been taken, and writes give no response. The two ports are released through separate output-enable pins rather than inout pins.

Top module: `pms_bus_seq`

## Requirements
- R1: During and after reset, req_ready_o is 1, both output enables and ale_o are 0, all three active-low strobes are 1, and rsp_valid_o is 0.
- R2: req_ready_o is 1 only when no bus cycle is running and no response is pending. A request is taken on a clock where req_valid_i and req_ready_o are both 1. mode_i is sampled only on that clock, so changing it later does not alter the cycle in progress.
- R3: In the miss phase (M ticks), hi_oe_o is 1, hi_addr_o carries request address bits [15:8] and ale_o is 1. All three strobes are inactive (1) and lo_oe_o is 0.
- R4: The hit cycle follows any miss phase and lasts 2M ticks. For its first M ticks, lo_oe_o is 1 and lo_ad_o carries address bits [7:0]. The second M ticks form the data half.
- R5: A miss stores the request's high byte as the page and marks the page valid. The first request after reset always misses. In mode 01, and for fetches in modes 10/11, a request misses exactly when its high byte differs from the stored page.
- R6: In mode 00, every data access misses. The next fetch after a mode-00 data access also misses, whatever its high byte.
- R7: In mode 10, a data access with a valid page never misses and leaves the page unchanged. hi_addr_o then carries the stored page, not the data address's high byte.
- R8: fetch_n_o is 0 for the whole hit cycle in mode 00 (2 ticks). In the other modes it is 0 only during the data half. It stays 1 for data accesses.
- R9: rd_n_o is 0 during the data half of a data read. wr_n_o is 0 during the data half of a data write, with lo_oe_o at 1 and lo_ad_o carrying the write byte. At most one strobe is active at a time.
- R10: For reads and fetches, lo_ad_i is sampled on the clock edge that ends the hit cycle and shown on rsp_data_o with rsp_valid_o. rsp_valid_o and rsp_data_o hold steady until rsp_ready_i is 1.
- R11: Mode 11 behaves exactly like mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two ticks per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Page timing mode, sampled at accept |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | 16 | Request address |
| req_fetch_i | input | 1 | 1 = code fetch, 0 = data access |
| req_write_i | input | 1 | 1 = data write (ignored for fetches) |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | Read byte valid |
| rsp_ready_i | input | 1 | Read byte accepted |
| rsp_data_o | output | 8 | Read byte |
| hi_addr_o | output | 8 | High address byte port |
| hi_oe_o | output | 1 | Output enable for the high port |
| lo_ad_o | output | 8 | Low address/data port, out direction |
| lo_oe_o | output | 1 | Output enable for the low port |
| lo_ad_i | input | 8 | Low address/data port, in direction |
| ale_o | output | 1 | Address latch strobe, active high |
| fetch_n_o | output | 1 | Program fetch strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |

## Verification
On every cycle, the assertions check the isolation of the miss phase: strobes inactive, low port released and high port driven whenever the latch strobe is high. They also check that at most one strobe is active, that a write strobe always comes with a driven low port, that the hit cycle opens with the low address driven, that the core is stalled while the bus is busy, and that a pending response holds. Only the bench scenarios can show that the miss decision is right per mode: forced misses around mode-00 data accesses, assumed page hits in modes 10/11, and compare-based misses otherwise. The same goes for phase and strobe lengths in ticks, the address bytes that the external latches capture, and the read byte sampled at the end of the hit cycle.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MISS = 2'd1,
    PH_HIT  = 2'd2
  } phase_t;

  localparam logic [1:0] MODE_FAST = 2'b00;
  localparam logic [1:0] MODE_MID  = 2'b01;
endpackage

// File: rtl/pms_page_track.sv
module pms_page_track #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            fetch_i,
  input  logic [HI_W-1:0] hi_i,
  input  logic            accept_i,
  output logic            miss_o,
  output logic [HI_W-1:0] page_o
);
  import pms_pkg::*;

  logic            valid_q;
  logic            force_q;
  logic [HI_W-1:0] page_q;
  logic            differs;

  assign differs = (hi_i != page_q);

  always_comb begin
    if (!valid_q) begin
      miss_o = 1'b1;
    end else begin
      case (mode_i)
        MODE_FAST: miss_o = !fetch_i || force_q || differs;
        MODE_MID:  miss_o = differs;
        default:   miss_o = fetch_i && differs;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      force_q <= 1'b0;
      page_q  <= '0;
    end else if (accept_i) begin
      if (miss_o) begin
        page_q  <= hi_i;
        valid_q <= 1'b1;
      end
      if (fetch_i) force_q <= 1'b0;
      else if (mode_i == MODE_FAST) force_q <= 1'b1;
    end
  end

  assign page_o = page_q;
endmodule

// File: rtl/pms_strobe_gen.sv
module pms_strobe_gen #(
  parameter int HI_W  = 8,
  parameter int LO_W  = 8,
  parameter int CNT_W = 3
) (
  input  pms_pkg::phase_t   phase_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  half_i,
  input  logic [1:0]        mode_i,
  input  logic              fetch_i,
  input  logic              write_i,
  input  logic [HI_W-1:0]   page_i,
  input  logic [LO_W-1:0]   addr_lo_i,
  input  logic [LO_W-1:0]   wdata_i,
  output logic [HI_W-1:0]   hi_addr_o,
  output logic              hi_oe_o,
  output logic [LO_W-1:0]   lo_ad_o,
  output logic              lo_oe_o,
  output logic              ale_o,
  output logic              fetch_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  import pms_pkg::*;

  logic in_hit;
  logic data_half;

  assign in_hit    = (phase_i == PH_HIT);
  assign data_half = in_hit && (cnt_i >= half_i);

  always_comb begin
    hi_oe_o   = (phase_i != PH_IDLE);
    hi_addr_o = hi_oe_o ? page_i : '0;
    ale_o     = (phase_i == PH_MISS);
    lo_oe_o   = in_hit && (!data_half || write_i);
    lo_ad_o   = '0;
    if (in_hit) lo_ad_o = data_half ? wdata_i : addr_lo_i;
    fetch_n_o = !(in_hit && fetch_i && ((mode_i == MODE_FAST) || data_half));
    rd_n_o    = !(data_half && !fetch_i && !write_i);
    wr_n_o    = !(data_half && write_i);
  end
endmodule

// File: rtl/pms_bus_seq.sv
module pms_bus_seq #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FAST_HALF = 1,
  parameter int MID_HALF  = 2,
  parameter int SLOW_HALF = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic                     req_fetch_i,
  input  logic                     req_write_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [DATA_W-1:0]        rsp_data_o,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  output logic                     hi_oe_o,
  output logic [DATA_W-1:0]        lo_ad_o,
  output logic                     lo_oe_o,
  input  logic [DATA_W-1:0]        lo_ad_i,
  output logic                     ale_o,
  output logic                     fetch_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o
);
  import pms_pkg::*;

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int CNT_W = $clog2(2 * SLOW_HALF);
  localparam logic [CNT_W:0] ONE = 1;

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half_q;
  logic [CNT_W-1:0]  half_d;
  logic [1:0]        mode_q;
  logic              fetch_q;
  logic              write_q;
  logic [DATA_W-1:0] addr_lo_q;
  logic [DATA_W-1:0] wdata_q;
  logic [HI_W-1:0]   page;
  logic              miss;
  logic              accept;
  logic              miss_end;
  logic              hit_end;

  always_comb begin
    case (mode_i)
      MODE_FAST: half_d = CNT_W'(FAST_HALF);
      MODE_MID:  half_d = CNT_W'(MID_HALF);
      default:   half_d = CNT_W'(SLOW_HALF);
    endcase
  end

  assign req_ready_o = (phase_q == PH_IDLE) && !rsp_valid_o;
  assign accept      = req_valid_i && req_ready_o;
  assign miss_end    = (cnt_q == half_q - 1'b1);
  assign hit_end     = ({1'b0, cnt_q} == ({1'b0, half_q} << 1) - ONE);

  pms_page_track #(.HI_W(HI_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .fetch_i  (req_fetch_i),
    .hi_i     (req_addr_i[ADDR_W-1:DATA_W]),
    .accept_i (accept),
    .miss_o   (miss),
    .page_o   (page)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      half_q      <= CNT_W'(FAST_HALF);
      mode_q      <= MODE_FAST;
      fetch_q     <= 1'b0;
      write_q     <= 1'b0;
      addr_lo_q   <= '0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      if (rsp_valid_o && rsp_ready_i) rsp_valid_o <= 1'b0;
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q   <= miss ? PH_MISS : PH_HIT;
          cnt_q     <= '0;
          half_q    <= half_d;
          mode_q    <= mode_i;
          fetch_q   <= req_fetch_i;
          write_q   <= req_write_i && !req_fetch_i;
          addr_lo_q <= req_addr_i[DATA_W-1:0];
          wdata_q   <= req_wdata_i;
        end
        PH_MISS: begin
          if (miss_end) begin
            phase_q <= PH_HIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (hit_end) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            if (!write_q) begin
              rsp_data_o  <= lo_ad_i;
              rsp_valid_o <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  pms_strobe_gen #(.HI_W(HI_W), .LO_W(DATA_W), .CNT_W(CNT_W)) u_strobe (
    .phase_i   (phase_q),
    .cnt_i     (cnt_q),
    .half_i    (half_q),
    .mode_i    (mode_q),
    .fetch_i   (fetch_q),
    .write_i   (write_q),
    .page_i    (page),
    .addr_lo_i (addr_lo_q),
    .wdata_i   (wdata_q),
    .hi_addr_o (hi_addr_o),
    .hi_oe_o   (hi_oe_o),
    .lo_ad_o   (lo_ad_o),
    .lo_oe_o   (lo_oe_o),
    .ale_o     (ale_o),
    .fetch_n_o (fetch_n_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o)
  );
endmodule

// File: rtl/pms_bus_seq_chk.sv
module pms_bus_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode_i,
  input logic                     req_valid_i,
  input logic                     req_ready_o,
  input logic [ADDR_W-1:0]        req_addr_i,
  input logic                     req_fetch_i,
  input logic                     req_write_i,
  input logic [DATA_W-1:0]        req_wdata_i,
  input logic                     rsp_valid_o,
  input logic                     rsp_ready_i,
  input logic [DATA_W-1:0]        rsp_data_o,
  input logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  input logic                     hi_oe_o,
  input logic [DATA_W-1:0]        lo_ad_o,
  input logic                     lo_oe_o,
  input logic [DATA_W-1:0]        lo_ad_i,
  input logic                     ale_o,
  input logic                     fetch_n_o,
  input logic                     rd_n_o,
  input logic                     wr_n_o
);
  // R3: miss phase keeps strobes quiet and the low port released
  a_r3_miss_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (fetch_n_o && rd_n_o && wr_n_o && !lo_oe_o && hi_oe_o));

  // R4: the hit cycle that follows a miss opens with the low address driven
  a_r4_hit_opens_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> (lo_oe_o && hi_oe_o));

  // R9: one strobe at a time
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!fetch_n_o, !rd_n_o, !wr_n_o}));

  // R9: write strobe only with the low port driven
  a_r9_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> lo_oe_o);

  // R2: no new request accepted while the bus is active
  a_r2_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_oe_o || rsp_valid_o) |-> !req_ready_o);

  // R10: a pending response holds until taken
  a_r10_rsp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
endmodule

bind pms_bus_seq pms_bus_seq_chk u_chk (.*);

// File: tb/pms_bus_seq_test.sv
module pms_bus_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [15:0] req_addr_i = '0;
  logic       req_fetch_i = 1'b0;
  logic       req_write_i = 1'b0;
  logic [7:0] req_wdata_i = '0;
  logic       rsp_valid_o;
  logic       rsp_ready_i = 1'b0;
  logic [7:0] rsp_data_o;
  logic [7:0] hi_addr_o;
  logic       hi_oe_o;
  logic [7:0] lo_ad_o;
  logic       lo_oe_o;
  logic [7:0] lo_ad_i;
  logic       ale_o, fetch_n_o, rd_n_o, wr_n_o;

  always #10 clk = ~clk;

  pms_bus_seq uut (.*);

  int checks = 0;
  int fails  = 0;

  // external latches and memory model
  logic [7:0] hi_lat = '0, lo_lat = '0;
  function automatic logic [7:0] mem_val(input logic [7:0] h, input logic [7:0] l);
    return h ^ {l[3:0], l[7:4]} ^ 8'h5A;
  endfunction
  assign lo_ad_i = mem_val(hi_lat, lo_lat);

  int ale_cnt, hit_cnt, f_cnt, r_cnt, w_cnt, bad_cnt;
  logic [7:0] ale_hi, w_hi, w_lo, w_data;

  always @(negedge clk) begin
    if (ale_o) begin
      hi_lat = hi_addr_o; ale_hi = hi_addr_o; ale_cnt++;
      if (!fetch_n_o || !rd_n_o || !wr_n_o || lo_oe_o) bad_cnt++;
    end
    if (hi_oe_o && !ale_o) hit_cnt++;
    if (lo_oe_o && wr_n_o && !ale_o) lo_lat = lo_ad_o;
    if (!fetch_n_o) f_cnt++;
    if (!rd_n_o) r_cnt++;
    if (!wr_n_o) begin
      w_cnt++; w_hi = hi_lat; w_lo = lo_lat; w_data = lo_ad_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench page model
  logic [7:0] bpage = '0;
  logic       bvalid = 1'b0, bforce = 1'b0;

  function automatic int half_of(input logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  task automatic txn(input logic [1:0] m, input logic [15:0] a, input logic f,
                     input logic w, input logic [7:0] d, input int stall);
    logic miss; logic [7:0] hi_eff; int h; logic is_wr;
    is_wr = w && !f;
    h = half_of(m);
    if (!bvalid) miss = 1;
    else if (m == 2'b00) miss = !f || bforce || (a[15:8] != bpage);
    else if (m == 2'b01) miss = (a[15:8] != bpage);
    else miss = f && (a[15:8] != bpage);
    hi_eff = miss ? a[15:8] : bpage;
    if (miss) begin bpage = a[15:8]; bvalid = 1; end
    if (f) bforce = 0; else if (m == 2'b00) bforce = 1;

    @(negedge clk); #2;
    while (!req_ready_o) begin @(negedge clk); #2; end
    ale_cnt = 0; hit_cnt = 0; f_cnt = 0; r_cnt = 0; w_cnt = 0; bad_cnt = 0;
    mode_i = m; req_addr_i = a; req_fetch_i = f; req_write_i = w; req_wdata_i = d;
    req_valid_i = 1;
    @(negedge clk); #2;
    req_valid_i = 0;
    mode_i = 2'($urandom);  // R2: later mode changes must not matter
    req_addr_i = 16'($urandom);
    while (!req_ready_o && !rsp_valid_o) begin @(negedge clk); #2; end

    chk("R3/R5/R6/R7 miss length", ale_cnt, miss ? h : 0);
    chk("R3 miss isolation", bad_cnt, 0);
    if (miss) chk("R3 high byte latched", ale_hi, a[15:8]);
    chk("R4 hit length", hit_cnt, 2 * h);
    chk("R8 fetch strobe ticks", f_cnt, f ? ((m == 2'b00) ? 2 : h) : 0);
    chk("R9 read strobe ticks", r_cnt, (!f && !is_wr) ? h : 0);
    chk("R9 write strobe ticks", w_cnt, is_wr ? h : 0);
    if (is_wr) begin
      chk("R9 write data", w_data, d);
      chk("R7/R9 write address", {w_hi, w_lo}, {hi_eff, a[7:0]});
      chk("R10 no response for write", rsp_valid_o, 0);
    end else begin
      chk("R10 read data", rsp_data_o, mem_val(hi_eff, a[7:0]));
      for (int i = 0; i < stall; i++) begin
        @(negedge clk); #2;
        chk("R10 response held", {rsp_valid_o, rsp_data_o}, {1'b1, mem_val(hi_eff, a[7:0])});
        chk("R2 stalled while pending", req_ready_o, 0);
      end
      rsp_ready_i = 1;
      @(negedge clk); #2;
      rsp_ready_i = 0;
      chk("R10 response cleared", rsp_valid_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset outputs", {req_ready_o, hi_oe_o, lo_oe_o, ale_o, fetch_n_o, rd_n_o, wr_n_o, rsp_valid_o},
        8'b1000_1110);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R1 idle after reset", {req_ready_o, hi_oe_o, lo_oe_o, ale_o, fetch_n_o, rd_n_o, wr_n_o, rsp_valid_o},
        8'b1000_1110);
    // directed corners
    txn(2'b01, 16'h1234, 1, 0, 8'h00, 0);  // R5 first access misses
    txn(2'b01, 16'h1240, 1, 0, 8'h00, 2);  // R5 same page hit
    txn(2'b00, 16'h1250, 0, 0, 8'h00, 1);  // R6 data forced miss
    txn(2'b00, 16'h1260, 1, 0, 8'h00, 0);  // R6 next fetch forced miss
    txn(2'b00, 16'h1270, 1, 0, 8'h00, 0);  // R8 mode 00 hit fetch
    txn(2'b10, 16'hAB11, 0, 1, 8'hC3, 0);  // R7 data write assumed hit
    txn(2'b11, 16'hCD22, 0, 0, 8'h00, 3);  // R11 mode 11 data read hit
    txn(2'b11, 16'hCD23, 1, 0, 8'h00, 0);  // R11 fetch compares page
    txn(2'b10, 16'h1299, 1, 0, 8'h00, 0);  // R5 fetch page change
    txn(2'b01, 16'h3401, 0, 1, 8'h77, 0);  // R5 data miss on change
    for (int n = 0; n < 400; n++) begin
      logic [7:0] hs [3];
      hs[0] = 8'h12; hs[1] = 8'h34; hs[2] = 8'hAB;
      txn(2'($urandom), {hs[$urandom % 3], 8'($urandom)}, 1'($urandom), 1'($urandom),
          8'($urandom), int'($urandom % 3));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule